// File: doc/BRIEF.md
# Transmit Queue Auto-Release Controller

This block drives a list of queued transmit packet numbers through a transmitter, one packet at a time. It takes a packet number from the queue while transmission is enabled and hands it to the MAC. It then waits for the MAC's completion report and settles what happens to that packet: its memory pages may be released to the page allocator, its number may be pushed into a completion FIFO, or it may be held as the failed packet.

With auto-release on, a successful packet gives its pages back on its own and leaves no trace in the completion FIFO. A run of such packets therefore interrupts the host only once, when the queue has drained. With auto-release off, every finished packet is logged in the completion FIFO and no pages are freed, so software does the release. In either mode a fatal error stops the run. Transmit-enable drops, the failed number is held in a register and its pages are kept. The host can fix the cause, acknowledge the error and set transmit-enable again, and the run resumes at the next queued packet.

Top module: `txq_release_ctrl`

## Requirements
- R1: After reset, tx_en, q_ready, mac_valid, rel_valid, done_ready, irq_empty, irq_err and cf_ovf are all 0, and the completion FIFO is empty (cf_level 0, cf_nempty 0).
- R2: A packet number is taken from the queue only while tx_en is 1 and no packet is in flight. Packets go to the MAC in queue order, and mac_valid and mac_num stay stable until mac_ready.
- R3: With auto_rel at 1, a successful completion produces one release request carrying that packet number. rel_valid and rel_num stay stable until rel_ready, and no further completion is accepted (done_ready 0) until the release is taken.
- R4: With auto_rel at 1, a completed packet is never written to the completion FIFO.
- R5: With auto_rel at 0, every completed packet, whether it succeeded or failed, is pushed into the completion FIFO in completion order, and no release request is made.
- R6: A completion with done_ok at 0 clears tx_en and loads fail_num with the failed packet number. No release is made for that packet, and no further queue entry is taken while tx_en stays 0.
- R7: A completion with done_ok at 0 sets irq_err.
- R8: irq_empty is set when a successful completion finishes (after its release, in auto mode) while q_valid is 0. A fault never sets it.
- R9: A one-cycle pulse on tx_en_set sets tx_en, and transmission resumes with the next queued packet after the failed one.
- R10: The completion FIFO holds 32 entries of 6 bits in first-in first-out order. A push while it is full is dropped and sets the sticky cf_ovf flag. A pop while it is empty has no effect.
- R11: irq_empty, irq_err and cf_ovf stay set until a 1 on ack_empty, ack_err or ack_ovf respectively. Each acknowledge clears only its own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| auto_rel | input | 1 | Auto-release mode select |
| tx_en_set | input | 1 | Pulse that sets transmit-enable |
| tx_en | output | 1 | Transmit-enable state |
| q_valid | input | 1 | A queued packet number is offered |
| q_num | input | 6 | Offered packet number |
| q_ready | output | 1 | Queue entry accepted this cycle when q_valid is 1 |
| mac_valid | output | 1 | Packet handed to the MAC |
| mac_num | output | 6 | Packet number for the MAC |
| mac_ready | input | 1 | MAC accepts the packet |
| done_valid | input | 1 | MAC completion report present |
| done_ok | input | 1 | 1 = success, 0 = fatal error |
| done_ready | output | 1 | Completion accepted |
| rel_valid | output | 1 | Page-release request |
| rel_num | output | 6 | Packet whose pages are released |
| rel_ready | input | 1 | Allocator takes the release |
| cf_pop | input | 1 | Pop the completion FIFO head |
| cf_num | output | 6 | Completion FIFO head |
| cf_nempty | output | 1 | Completion FIFO holds data |
| cf_level | output | 6 | Completion FIFO occupancy |
| fail_num | output | 6 | Last fatally failed packet number |
| irq_empty | output | 1 | Sticky queue-drained interrupt |
| irq_err | output | 1 | Sticky transmit-error interrupt |
| cf_ovf | output | 1 | Sticky completion FIFO overflow |
| ack_empty | input | 1 | Clears irq_empty |
| ack_err | input | 1 | Clears irq_err |
| ack_ovf | input | 1 | Clears cf_ovf |

## Verification
The assertions assume that the MAC raises done_valid only for a packet it has already taken, and holds it until done_ready. They also assume that q_valid and q_num stay stable while offered, and that auto_rel is not changed while a packet is in flight. The bench models the MAC, the queue and the allocator as handshake threads that keep to these rules. The threads randomise the ready signals and the completion delays, and they change the queue and the mode only between runs. The expected release list, FIFO contents, failed number and flags come from the first failing index of each packet list.

// File: rtl/txq_pkg.sv
package txq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_SEND = 2'd1,
    ST_WAIT = 2'd2,
    ST_REL  = 2'd3
  } txq_state_e;

  localparam int FLAG_EMPTY = 0;
  localparam int FLAG_ERR   = 1;
  localparam int FLAG_OVF   = 2;
  localparam int NUM_FLAGS  = 3;
endpackage

// File: rtl/txq_cfifo.sv
// Completion FIFO; DEPTH must be a power of two.
module txq_cfifo #(
  parameter int W     = 6,
  parameter int DEPTH = 32,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [W-1:0]  push_data,
  input  logic          pop,
  output logic [W-1:0]  rd_data,
  output logic          nempty,
  output logic [LW-1:0] level,
  output logic          ovf_pulse
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic          full, push_ok, pop_ok;

  assign full      = (level == LW'(DEPTH));
  assign nempty    = (level != '0);
  assign push_ok   = push && !full;
  assign pop_ok    = pop && nempty;
  assign ovf_pulse = push && full;
  assign rd_data   = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + AW'(1);
      if (pop_ok)  rd_ptr <= rd_ptr + AW'(1);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  // R10
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (push && full && !pop) |=> (level == LW'(DEPTH)));
  // R10
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop && !nempty && !push) |=> (level == '0));
endmodule

// File: rtl/txq_flags.sv
module txq_flags #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] set,
  input  logic [N-1:0] ack,
  output logic [N-1:0] flags
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (ack[i]) flags[i] <= 1'b0;
    end

    // R11
    sticky_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !ack[i]) |=> flags[i]);
  end
endmodule

// File: rtl/txq_release_ctrl.sv
module txq_release_ctrl
  import txq_pkg::*;
#(
  parameter int NUM_W    = 6,
  parameter int CF_DEPTH = 32,
  localparam int LW      = $clog2(CF_DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             auto_rel,
  input  logic             tx_en_set,
  output logic             tx_en,
  input  logic             q_valid,
  input  logic [NUM_W-1:0] q_num,
  output logic             q_ready,
  output logic             mac_valid,
  output logic [NUM_W-1:0] mac_num,
  input  logic             mac_ready,
  input  logic             done_valid,
  input  logic             done_ok,
  output logic             done_ready,
  output logic             rel_valid,
  output logic [NUM_W-1:0] rel_num,
  input  logic             rel_ready,
  input  logic             cf_pop,
  output logic [NUM_W-1:0] cf_num,
  output logic             cf_nempty,
  output logic [LW-1:0]    cf_level,
  output logic [NUM_W-1:0] fail_num,
  output logic             irq_empty,
  output logic             irq_err,
  output logic             cf_ovf,
  input  logic             ack_empty,
  input  logic             ack_err,
  input  logic             ack_ovf
);
  txq_state_e       st;
  logic [NUM_W-1:0] cur_num;
  logic             done_acc, fault, push, ovf_pulse, rel_done;
  logic [NUM_FLAGS-1:0] flag_set, flag_ack, flag_q;

  assign q_ready    = (st == ST_IDLE) && tx_en;
  assign mac_valid  = (st == ST_SEND);
  assign mac_num    = cur_num;
  assign done_ready = (st == ST_WAIT);
  assign rel_valid  = (st == ST_REL);
  assign rel_num    = cur_num;

  assign done_acc = done_ready && done_valid;
  assign fault    = done_acc && !done_ok;
  assign push     = done_acc && !auto_rel;
  assign rel_done = rel_valid && rel_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      cur_num  <= '0;
      tx_en    <= 1'b0;
      fail_num <= '0;
    end else begin
      if (fault)          tx_en <= 1'b0;
      else if (tx_en_set) tx_en <= 1'b1;
      unique case (st)
        ST_IDLE: if (q_ready && q_valid) begin
          cur_num <= q_num;
          st      <= ST_SEND;
        end
        ST_SEND: if (mac_ready) st <= ST_WAIT;
        ST_WAIT: if (done_valid) begin
          if (done_ok) st <= auto_rel ? ST_REL : ST_IDLE;
          else begin
            st       <= ST_IDLE;
            fail_num <= cur_num;
          end
        end
        ST_REL:  if (rel_ready) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    flag_set             = '0;
    flag_set[FLAG_EMPTY] = !q_valid && ((done_acc && done_ok && !auto_rel) || rel_done);
    flag_set[FLAG_ERR]   = fault;
    flag_set[FLAG_OVF]   = ovf_pulse;
    flag_ack             = '0;
    flag_ack[FLAG_EMPTY] = ack_empty;
    flag_ack[FLAG_ERR]   = ack_err;
    flag_ack[FLAG_OVF]   = ack_ovf;
  end

  txq_flags #(.N(NUM_FLAGS)) u_flags (
    .clk(clk), .rst(rst), .set(flag_set), .ack(flag_ack), .flags(flag_q)
  );

  assign irq_empty = flag_q[FLAG_EMPTY];
  assign irq_err   = flag_q[FLAG_ERR];
  assign cf_ovf    = flag_q[FLAG_OVF];

  txq_cfifo #(.W(NUM_W), .DEPTH(CF_DEPTH)) u_cfifo (
    .clk(clk), .rst(rst), .push(push), .push_data(cur_num), .pop(cf_pop),
    .rd_data(cf_num), .nempty(cf_nempty), .level(cf_level), .ovf_pulse(ovf_pulse)
  );

  // R2
  mac_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mac_valid && !mac_ready) |=> (mac_valid && $stable(mac_num)));
  // R3
  rel_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rel_valid && !rel_ready) |=> (rel_valid && $stable(rel_num) && !done_ready));
  // R5
  no_auto_rel_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_ready && !auto_rel) |=> !rel_valid);
  // R6
  fault_stop_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_ready && !done_ok) |=> (!tx_en && !q_ready && !rel_valid
      && fail_num == $past(mac_num)));
  // R7
  fault_irq_chk: assert property (@(posedge clk) disable iff (rst)
    (done_valid && done_ready && !done_ok) |=> irq_err);
endmodule

// File: tb/txq_release_ctrl_tb.sv
module txq_release_ctrl_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic auto_rel = 1'b0, tx_en_set = 1'b0, tx_en;
  logic q_valid = 1'b0; logic [5:0] q_num = '0; logic q_ready;
  logic mac_valid; logic [5:0] mac_num; logic mac_ready = 1'b0;
  logic done_valid = 1'b0, done_ok = 1'b0, done_ready;
  logic rel_valid; logic [5:0] rel_num; logic rel_ready = 1'b0;
  logic cf_pop = 1'b0; logic [5:0] cf_num; logic cf_nempty; logic [5:0] cf_level;
  logic [5:0] fail_num;
  logic irq_empty, irq_err, cf_ovf;
  logic ack_empty = 1'b0, ack_err = 1'b0, ack_ovf = 1'b0;

  always #10 clk = ~clk;

  txq_release_ctrl u_dut (
    .clk(clk), .rst(rst), .auto_rel(auto_rel), .tx_en_set(tx_en_set), .tx_en(tx_en),
    .q_valid(q_valid), .q_num(q_num), .q_ready(q_ready),
    .mac_valid(mac_valid), .mac_num(mac_num), .mac_ready(mac_ready),
    .done_valid(done_valid), .done_ok(done_ok), .done_ready(done_ready),
    .rel_valid(rel_valid), .rel_num(rel_num), .rel_ready(rel_ready),
    .cf_pop(cf_pop), .cf_num(cf_num), .cf_nempty(cf_nempty), .cf_level(cf_level),
    .fail_num(fail_num), .irq_empty(irq_empty), .irq_err(irq_err), .cf_ovf(cf_ovf),
    .ack_empty(ack_empty), .ack_err(ack_err), .ack_ovf(ack_ovf)
  );

  int n_tests = 0, n_fail = 0;
  logic [5:0] pk_num [64];
  bit         pk_ok  [64];
  int         pk_n, qi, sent_c, rel_c;
  logic [5:0] sent_l [64];
  logic [5:0] rel_l  [64];
  bit         running;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int first_fail();
    for (int j = 0; j < pk_n; j++) if (!pk_ok[j]) return j;
    return pk_n;
  endfunction

  task automatic run_cycles(input int cyc);
    running = 1'b1;
    fork
      begin
        repeat (cyc) @(negedge clk);
        running = 1'b0;
      end
      begin : q_thread
        bit fire;
        fire = 1'b0;
        while (running) begin
          @(negedge clk);
          if (fire) qi++;
          q_valid = (qi < pk_n);
          q_num   = q_valid ? pk_num[qi] : 6'd0;
          fire    = q_valid && q_ready;
        end
        q_valid = 1'b0;
      end
      begin : mac_thread
        bit mfire, dfire, infl;
        int dly;
        logic [5:0] pend;
        mfire = 1'b0; dfire = 1'b0; infl = 1'b0; dly = 0; pend = '0;
        while (running) begin
          @(negedge clk);
          if (dfire) begin done_valid = 1'b0; infl = 1'b0; end
          if (mfire) begin
            sent_l[sent_c] = pend;
            sent_c++;
            infl = 1'b1;
            dly  = int'($urandom % 4);
          end
          mac_ready = 1'($urandom % 2);
          if (infl && !done_valid) begin
            if (dly == 0) begin done_valid = 1'b1; done_ok = pk_ok[sent_c-1]; end
            else dly--;
          end
          mfire = mac_valid && mac_ready;
          pend  = mac_num;
          dfire = done_valid && done_ready;
        end
        done_valid = 1'b0;
        mac_ready  = 1'b0;
      end
      begin : rel_thread
        bit rf;
        logic [5:0] rp;
        rf = 1'b0; rp = '0;
        while (running) begin
          @(negedge clk);
          if (rf) begin rel_l[rel_c] = rp; rel_c++; end
          rel_ready = 1'($urandom % 2);
          rf = rel_valid && rel_ready;
          rp = rel_num;
        end
        rel_ready = 1'b0;
      end
    join
  endtask

  task automatic pulse_en();
    @(negedge clk); tx_en_set = 1'b1;
    @(negedge clk); tx_en_set = 1'b0;
  endtask

  task automatic ack_all();
    @(negedge clk); ack_empty = 1'b1; ack_err = 1'b1; ack_ovf = 1'b1;
    @(negedge clk); ack_empty = 1'b0; ack_err = 1'b0; ack_ovf = 1'b0;
  endtask

  task automatic drain_check(input int exp_cnt, input string req);
    int got;
    got = 0;
    while (cf_nempty) begin
      chk(got < exp_cnt && cf_num == pk_num[got], req, "fifo entry", cf_num, pk_num[got]);
      got++;
      cf_pop = 1'b1;
      @(negedge clk);
      cf_pop = 1'b0;
      @(negedge clk);
    end
    chk(got == exp_cnt, req, "fifo entry count", got, exp_cnt);
  endtask

  task automatic scenario(input bit au);
    int ff, es, ef;
    qi = 0; sent_c = 0; rel_c = 0;
    auto_rel = au;
    pulse_en();
    run_cycles(40 * pk_n + 40);
    ff = first_fail();
    es = (ff < pk_n) ? ff + 1 : pk_n;
    ef = au ? 0 : ((es > 32) ? 32 : es);
    chk(sent_c == es, "R2", "packets sent", sent_c, es);
    for (int j = 0; j < es && j < sent_c; j++)
      chk(sent_l[j] == pk_num[j], "R2", "send order", sent_l[j], pk_num[j]);
    if (au) begin
      chk(rel_c == ff, "R3", "release count", rel_c, ff);
      for (int j = 0; j < ff && j < rel_c; j++)
        chk(rel_l[j] == pk_num[j], "R3", "release number", rel_l[j], pk_num[j]);
      chk(cf_level == 0, "R4", "fifo level in auto mode", cf_level, 0);
    end else begin
      chk(rel_c == 0, "R5", "no release without auto", rel_c, 0);
      chk(cf_level == 6'(ef), "R5", "fifo level", cf_level, ef);
    end
    chk(tx_en == (ff == pk_n), "R6", "tx_en after run", tx_en, ff == pk_n);
    chk(irq_err == (ff < pk_n), "R7", "irq_err", irq_err, ff < pk_n);
    chk(irq_empty == (ff == pk_n), "R8", "irq_empty", irq_empty, ff == pk_n);
    if (ff < pk_n) chk(fail_num == pk_num[ff], "R6", "fail_num", fail_num, pk_num[ff]);
    chk(cf_ovf == (!au && es > 32), "R10", "overflow flag", cf_ovf, !au && es > 32);
    if (!au) drain_check(ef, "R5");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!tx_en && !q_ready && !mac_valid && !rel_valid && !done_ready, "R1", "handshake outputs idle",
        {tx_en, q_ready, mac_valid, rel_valid, done_ready}, 0);
    chk(!irq_empty && !irq_err && !cf_ovf, "R1", "flags clear", {irq_empty, irq_err, cf_ovf}, 0);
    chk(cf_level == 0 && !cf_nempty, "R1", "fifo empty", cf_level, 0);

    // auto mode, all successful
    pk_n = 4;
    for (int j = 0; j < 4; j++) begin pk_num[j] = 6'(10 + j); pk_ok[j] = 1'b1; end
    scenario(1'b1);
    // R11 sticky and per-flag acknowledge
    repeat (5) @(negedge clk);
    chk(irq_empty, "R11", "irq_empty held", irq_empty, 1);
    ack_err = 1'b1; @(negedge clk); ack_err = 1'b0; @(negedge clk);
    chk(irq_empty, "R11", "irq_empty kept by other ack", irq_empty, 1);
    ack_empty = 1'b1; @(negedge clk); ack_empty = 1'b0; @(negedge clk);
    chk(!irq_empty, "R11", "irq_empty cleared by ack", irq_empty, 0);

    // auto mode with fatal error on the second packet, then restart
    pk_n = 4;
    for (int j = 0; j < 4; j++) begin pk_num[j] = 6'(40 + j); pk_ok[j] = (j != 1); end
    scenario(1'b1);
    ack_err = 1'b1; @(negedge clk); ack_err = 1'b0; @(negedge clk);
    chk(!irq_err, "R11", "irq_err cleared by ack", irq_err, 0);
    pk_ok[1] = 1'b1;
    pulse_en();
    chk(tx_en, "R9", "tx_en set by pulse", tx_en, 1);
    run_cycles(200);
    chk(sent_c == 4, "R9", "resume sends rest", sent_c, 4);
    chk(rel_c == 3 && rel_l[1] == pk_num[2] && rel_l[2] == pk_num[3], "R9", "release after restart",
        rel_l[1], pk_num[2]);
    chk(fail_num == 6'd41, "R6", "fail_num kept", fail_num, 41);
    chk(irq_empty && tx_en, "R9", "drained after restart", irq_empty, 1);
    ack_all();

    // non-auto with a failure: failed packet also logged
    pk_n = 5;
    for (int j = 0; j < 5; j++) begin pk_num[j] = 6'(j * 7 + 1); pk_ok[j] = (j != 3); end
    scenario(1'b0);
    ack_all();

    // overflow of the completion FIFO
    pk_n = 34;
    for (int j = 0; j < 34; j++) begin pk_num[j] = 6'(j + 20); pk_ok[j] = 1'b1; end
    scenario(1'b0);
    ack_all();
    chk(!cf_ovf, "R11", "cf_ovf cleared by ack", cf_ovf, 0);
    // R10 pop on empty ignored
    cf_pop = 1'b1; @(negedge clk); cf_pop = 1'b0; @(negedge clk);
    chk(cf_level == 0 && !cf_nempty, "R10", "pop on empty ignored", cf_level, 0);

    // random runs
    for (int s = 0; s < 10; s++) begin
      pk_n = 1 + int'($urandom % 8);
      for (int j = 0; j < pk_n; j++) begin
        pk_num[j] = 6'($urandom);
        pk_ok[j]  = ($urandom % 6) != 0;
      end
      scenario(1'($urandom % 2));
      ack_all();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule